// File: doc/BRIEF.md
# Font Glyph Row Expander

The block draws one character of a monochrome 8-pixel-wide bitmap font into an 8-bit-per-pixel frame buffer. A single start pulse supplies the parameters: a character code, a glyph height in scan lines, a destination base address, a line pitch in bytes, and a foreground and a background colour byte. For each scan line of the glyph, the block reads one font byte through a synchronous read port. It expands that byte into eight colour bytes in a local register. It then offers the eight bytes as one 8-byte write burst with a per-byte strobe mask.

The font table is laid out scan-line-major with 256 glyphs per line. The byte for scan line `y` of character `c` therefore sits at offset `y*256 + c`. When the foreground and background colours are equal, the glyph is drawn transparently. Only the pixels whose font bit is set are enabled for writing, and the frame-buffer bytes behind the clear bits are left untouched.

The write port is valid/ready. The block raises `wr_valid` and holds address, data and strobe steady until a cycle in which `wr_ready` is high. That cycle counts as acceptance. The block does not fetch the next font byte until the current row has been accepted. Back-pressure can last any number of cycles and never loses or reorders a row.

Top module: `glyph_row_expander`

## Requirements
- R1: For scan line `r`, the block pulses `font_rd` for exactly one cycle with `font_addr = r*256 + char_code[7:0]`. `font_data` is taken in the cycle after that pulse (one-cycle read latency).
- R2: Pixel `i` of a row goes to byte lane `i` of `wr_data`, in bits `8i+7:8i`. Lane 0 is the leftmost pixel and comes from font bit 0. Lane 7 comes from font bit 7.
- R3: A lane whose font bit is 1 carries the foreground byte. A lane whose font bit is 0 carries the background byte.
- R4: When foreground differs from background, `wr_strobe` is `8'hFF`. When they are equal, `wr_strobe` equals the font byte, so clear-bit lanes are not written.
- R5: Rows are emitted in order 0 to height-1. Row `r` is written at `wr_addr = base + r*pitch`, modulo 2^32.
- R6: Exactly one write burst is offered per row. It first appears two cycles after that row's `font_rd`. The next `font_rd` comes in the cycle after acceptance, and `wr_valid` is low in that cycle.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_strobe` stay unchanged.
- R8: `busy` is high from the cycle after an accepted start until the final row is accepted. `done` is then high for exactly one cycle, with `busy` low in that cycle.
- R9: `start` is accepted only when the block is idle. This means neither busy nor in its done cycle. A start at any other time has no effect on the current glyph or on the cycle after `done`.
- R10: A start with height 0 causes no font read and no write. `busy` stays low, and `done` pulses in the next cycle.
- R11: After reset, `busy`, `done`, `font_rd` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; parameters sampled with it |
| char_code | input | 8 | Character code |
| glyph_rows | input | HEIGHT_W | Glyph height in scan lines |
| dst_base | input | ADDR_W | Byte address of the top-left pixel |
| line_pitch | input | PITCH_W | Bytes between consecutive frame-buffer lines |
| fg_color | input | 8 | Foreground colour byte |
| bg_color | input | 8 | Background colour byte |
| font_rd | output | 1 | Font read strobe |
| font_addr | output | HEIGHT_W+8 | Font table byte offset |
| font_data | input | 8 | Font byte, valid the cycle after `font_rd` |
| wr_valid | output | 1 | Row write offered |
| wr_ready | input | 1 | Row write accepted when high with `wr_valid` |
| wr_addr | output | ADDR_W | Row write byte address |
| wr_data | output | 64 | Eight pixel bytes, lane 0 leftmost |
| wr_strobe | output | 8 | Per-lane write enable |
| busy | output | 1 | Glyph in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle. One is the acceptance of the final row, which ends `busy`, and the other is a new `start` in the following done cycle. The bench provokes this by raising `start` exactly in the `done` cycle, with fresh parameters. It judges the result by checking that no font read or write follows. The second collision is a ready pulse in the very first cycle `wr_valid` rises, against long stalls. The bench drives always-ready, alternating, pseudo-random and held-low ready patterns. A behavioural model predicts every output on every cycle.

// File: rtl/gre_pkg.sv
package gre_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CAPT,
    ST_SEND,
    ST_FIN
  } gre_state_e;

  localparam int unsigned PIX_PER_ROW = 8;
  localparam int unsigned PIX_BITS    = 8;
endpackage

// File: rtl/gre_seq.sv
module gre_seq
  import gre_pkg::*;
#(
  parameter int unsigned HEIGHT_W = 5,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned PITCH_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [HEIGHT_W-1:0] glyph_rows,
  input  logic [ADDR_W-1:0]   dst_base,
  input  logic [PITCH_W-1:0]  line_pitch,
  input  logic                wr_ready,
  output gre_state_e          state,
  output logic [HEIGHT_W-1:0] row_idx,
  output logic [ADDR_W-1:0]   row_addr,
  output logic                take_start
);
  logic [HEIGHT_W-1:0] rows_q;
  logic [PITCH_W-1:0]  pitch_q;
  logic                last_row;

  assign take_start = (state == ST_IDLE) && start;
  assign last_row   = (row_idx == rows_q - HEIGHT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rows_q   <= '0;
      pitch_q  <= '0;
      row_idx  <= '0;
      row_addr <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            rows_q   <= glyph_rows;
            pitch_q  <= line_pitch;
            row_idx  <= '0;
            row_addr <= dst_base;
            state    <= (glyph_rows == '0) ? ST_FIN : ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_CAPT;
        ST_CAPT:  state <= ST_SEND;
        ST_SEND: begin
          if (wr_ready) begin
            if (last_row) begin
              state <= ST_FIN;
            end else begin
              row_idx  <= row_idx + HEIGHT_W'(1);
              row_addr <= row_addr + ADDR_W'(pitch_q);
              state    <= ST_FETCH;
            end
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gre_font_addr.sv
module gre_font_addr
  import gre_pkg::*;
#(
  parameter int unsigned HEIGHT_W = 5,
  localparam int unsigned FONT_AW = HEIGHT_W + 8
) (
  input  gre_state_e          state,
  input  logic [HEIGHT_W-1:0] row_idx,
  input  logic [7:0]          char_q,
  output logic                font_rd,
  output logic [FONT_AW-1:0]  font_addr
);
  // scan-line-major table: 256 glyph bytes per scan line
  assign font_rd   = (state == ST_FETCH);
  assign font_addr = {row_idx, char_q};
endmodule

// File: rtl/gre_pixel_expand.sv
module gre_pixel_expand
  import gre_pkg::*;
#(
  parameter int unsigned LANES = PIX_PER_ROW,
  localparam int unsigned DW   = LANES * PIX_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic [LANES-1:0]    font_bits,
  input  logic [PIX_BITS-1:0] fg,
  input  logic [PIX_BITS-1:0] bg,
  output logic [DW-1:0]       pix_data,
  output logic [LANES-1:0]    pix_strobe
);
  logic see_through;
  assign see_through = (fg == bg);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pix_data[i*PIX_BITS +: PIX_BITS] <= '0;
        pix_strobe[i]                    <= 1'b0;
      end else if (capture) begin
        pix_data[i*PIX_BITS +: PIX_BITS] <= font_bits[i] ? fg : bg;
        pix_strobe[i]                    <= font_bits[i] | ~see_through;
      end
    end
  end
endmodule

// File: rtl/glyph_row_expander.sv
module glyph_row_expander
  import gre_pkg::*;
#(
  parameter int unsigned HEIGHT_W = 5,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned PITCH_W  = 16,
  localparam int unsigned FONT_AW = HEIGHT_W + 8,
  localparam int unsigned DW      = PIX_PER_ROW * PIX_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [7:0]          char_code,
  input  logic [HEIGHT_W-1:0] glyph_rows,
  input  logic [ADDR_W-1:0]   dst_base,
  input  logic [PITCH_W-1:0]  line_pitch,
  input  logic [7:0]          fg_color,
  input  logic [7:0]          bg_color,
  output logic                font_rd,
  output logic [FONT_AW-1:0]  font_addr,
  input  logic [7:0]          font_data,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [DW-1:0]       wr_data,
  output logic [7:0]          wr_strobe,
  output logic                busy,
  output logic                done
);
  gre_state_e          state;
  logic [HEIGHT_W-1:0] row_idx;
  logic                take_start;
  logic [7:0]          char_q, fg_q, bg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      char_q <= '0;
      fg_q   <= '0;
      bg_q   <= '0;
    end else if (take_start) begin
      char_q <= char_code;
      fg_q   <= fg_color;
      bg_q   <= bg_color;
    end
  end

  gre_seq #(
    .HEIGHT_W(HEIGHT_W), .ADDR_W(ADDR_W), .PITCH_W(PITCH_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .glyph_rows(glyph_rows),
    .dst_base(dst_base), .line_pitch(line_pitch), .wr_ready(wr_ready),
    .state(state), .row_idx(row_idx), .row_addr(wr_addr),
    .take_start(take_start)
  );

  gre_font_addr #(.HEIGHT_W(HEIGHT_W)) u_faddr (
    .state(state), .row_idx(row_idx), .char_q(char_q),
    .font_rd(font_rd), .font_addr(font_addr)
  );

  gre_pixel_expand #(.LANES(PIX_PER_ROW)) u_expand (
    .clk(clk), .rst_n(rst_n), .capture(state == ST_CAPT),
    .font_bits(font_data), .fg(fg_q), .bg(bg_q),
    .pix_data(wr_data), .pix_strobe(wr_strobe)
  );

  assign wr_valid = (state == ST_SEND);
  assign busy     = (state == ST_FETCH) || (state == ST_CAPT) || (state == ST_SEND);
  assign done     = (state == ST_FIN);
endmodule

// File: rtl/gre_checker.sv
module gre_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              font_rd,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [63:0]       wr_data,
  input logic [7:0]        wr_strobe
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) &&
                                 $stable(wr_data) && $stable(wr_strobe)));

  assert_read_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    font_rd |=> (!font_rd && !wr_valid));

  assert_gap_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_valid);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_activity_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (font_rd || wr_valid) |-> busy);

  assert_start_in_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!busy && !done));
endmodule

bind glyph_row_expander gre_checker #(.ADDR_W(ADDR_W)) u_gre_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .font_rd(font_rd), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_strobe(wr_strobe)
);

// File: tb/glyph_row_expander_bench.sv
module glyph_row_expander_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  char_code = '0;
  logic [4:0]  glyph_rows = '0;
  logic [31:0] dst_base = '0;
  logic [15:0] line_pitch = '0;
  logic [7:0]  fg_color = '0, bg_color = '0;
  logic        font_rd;
  logic [12:0] font_addr;
  logic [7:0]  font_data = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_strobe;
  logic        busy, done;

  glyph_row_expander u_glyph_row_expander (
    .clk(clk), .rst_n(rst_n), .start(start), .char_code(char_code),
    .glyph_rows(glyph_rows), .dst_base(dst_base), .line_pitch(line_pitch),
    .fg_color(fg_color), .bg_color(bg_color), .font_rd(font_rd),
    .font_addr(font_addr), .font_data(font_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_strobe(wr_strobe), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  int rmode    = 0;
  logic [7:0] lfsr = 8'h5A;
  bit   compare_on = 1'b0;

  function automatic logic [7:0] font_byte(int a);
    return 8'((a * 37) ^ (a >> 3) ^ 8'h5C);
  endfunction

  // font memory with one-cycle latency
  always @(posedge clk) if (font_rd) font_data <= font_byte(int'(font_addr));

  // ready pattern driven away from the active edge
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (rmode)
      0: wr_ready <= 1'b1;
      1: wr_ready <= ~wr_ready;
      2: wr_ready <= lfsr[0] & lfsr[3];
      default: wr_ready <= 1'b0;
    endcase
  end

  // behavioural reference: 0 idle, 1 fetch, 2 capture, 3 offer, 4 done
  int          m_st = 0;
  int          m_row, m_rows;
  logic [31:0] m_addr;
  logic [15:0] m_pitch;
  logic [7:0]  m_ch, m_fg, m_bg;

  always @(posedge clk) begin
    if (!rst_n) m_st = 0;
    else begin
      case (m_st)
        0: if (start) begin
             m_rows = int'(glyph_rows); m_pitch = line_pitch; m_addr = dst_base;
             m_ch = char_code; m_fg = fg_color; m_bg = bg_color; m_row = 0;
             m_st = (glyph_rows == 0) ? 4 : 1;
           end
        1: m_st = 2;
        2: m_st = 3;
        3: if (wr_ready) begin
             if (m_row == m_rows - 1) m_st = 4;
             else begin m_row++; m_addr = m_addr + 32'(m_pitch); m_st = 1; end
           end
        default: m_st = 0;
      endcase
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (compare_on) begin
      logic [7:0]  fb;
      logic [63:0] ed;
      logic [7:0]  es;
      fb = font_byte(m_row * 256 + int'(m_ch));
      for (int i = 0; i < 8; i++) ed[i*8 +: 8] = fb[i] ? m_fg : m_bg;
      es = (m_fg == m_bg) ? fb : 8'hFF;
      chk(busy == (m_st >= 1 && m_st <= 3), "R8 busy", 64'(busy), 64'(m_st >= 1 && m_st <= 3));
      chk(done == (m_st == 4), "R8/R9/R10 done", 64'(done), 64'(m_st == 4));
      chk(font_rd == (m_st == 1), "R1/R6 font_rd", 64'(font_rd), 64'(m_st == 1));
      chk(wr_valid == (m_st == 3), "R6/R7 wr_valid", 64'(wr_valid), 64'(m_st == 3));
      if (m_st == 1)
        chk(font_addr == 13'(m_row * 256 + int'(m_ch)), "R1 font_addr",
            64'(font_addr), 64'(m_row * 256 + int'(m_ch)));
      if (m_st == 3) begin
        chk(wr_addr == m_addr, "R5 wr_addr", 64'(wr_addr), 64'(m_addr));
        chk(wr_data == ed, "R2/R3 wr_data", wr_data, ed);
        chk(wr_strobe == es, "R4 wr_strobe", 64'(wr_strobe), 64'(es));
      end
    end
    if (cycles > 150000) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (m_st != 0);
  endtask

  task automatic glyph(input logic [7:0] ch, input logic [4:0] rows, input logic [31:0] base,
                       input logic [15:0] pitch, input logic [7:0] fg, input logic [7:0] bg,
                       input int mode);
    @(negedge clk);
    rmode = mode;
    char_code = ch; glyph_rows = rows; dst_base = base; line_pitch = pitch;
    fg_color = fg; bg_color = bg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !font_rd && !wr_valid, "R11 reset outputs",
        64'({busy, done, font_rd, wr_valid}), 64'(0));
    rst_n = 1'b1;
    compare_on = 1'b1;
    // R1 R2 R3 R5: opaque glyphs, several codes and patterns
    glyph(8'h41, 5'd8,  32'h0000_1000, 16'd640,  8'h0F, 8'h00, 0);
    glyph(8'h00, 5'd3,  32'h0000_0000, 16'd1920, 8'hAA, 8'h55, 1);
    glyph(8'hFF, 5'd16, 32'h1234_5670, 16'd1024, 8'h80, 8'h7F, 2);
    // R4 transparent draw
    glyph(8'h7E, 5'd12, 32'h0002_0000, 16'd800,  8'h33, 8'h33, 2);
    // R5 address wrap past 2^32
    glyph(8'h10, 5'd4,  32'hFFFF_FF00, 16'hFFFF, 8'h01, 8'h02, 1);
    // R10 zero height; R6 single row; maximum height
    glyph(8'h20, 5'd0,  32'h0000_4000, 16'd64,   8'h11, 8'h22, 0);
    glyph(8'h21, 5'd1,  32'h0000_4000, 16'd64,   8'h11, 8'h22, 0);
    glyph(8'hC3, 5'd31, 32'h0010_0000, 16'd320,  8'hE0, 8'h1C, 2);
    // R7 long stall, then release
    @(negedge clk);
    rmode = 3;
    char_code = 8'h5A; glyph_rows = 5'd2; dst_base = 32'h800; line_pitch = 16'd256;
    fg_color = 8'h99; bg_color = 8'h66; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (25) @(negedge clk);
    rmode = 0;
    wait_idle();
    // R9 start while busy is ignored
    @(negedge clk);
    rmode = 1;
    char_code = 8'h44; glyph_rows = 5'd6; dst_base = 32'h3000; line_pitch = 16'd100;
    fg_color = 8'h05; bg_color = 8'h06; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    char_code = 8'h99; glyph_rows = 5'd2; dst_base = 32'hDEAD_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9 start in the done cycle is ignored
    do @(negedge clk); while (m_st != 4);
    char_code = 8'h77; glyph_rows = 5'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk(!busy && !font_rd && !wr_valid, "R9 no work after done-cycle start",
        64'({busy, font_rd, wr_valid}), 64'(0));
    // back-to-back randomised glyphs
    for (int k = 0; k < 20; k++)
      glyph(8'(k * 13 + 7), 5'(k % 9 + 1), 32'(k * 4096), 16'(k * 40 + 8),
            8'(k * 3), 8'((k % 4 == 0) ? k * 3 : k * 5 + 1), k % 3);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule